// File: doc/BRIEF.md
# PMBus Write Frame Receiver with PEC Check

This block sits behind an SMBus slave bit engine that already turns the wire activity into bytes and bus-condition strobes. It rebuilds each PMBus write transaction from that stream. A transaction holds a slave address, a command code, zero to two data bytes and an optional checksum byte. A CRC-8 runs over every byte of a frame, starting with the address byte. When the frame ends, the block decides from the byte count whether a checksum byte was sent and, if so, checks it. Accepted writes leave the block as a command code and a 16-bit data word, together with the data length, a flag that shows a checksum was used, and a tag for manufacturer-range commands. A checksum mismatch and a malformed frame each give a one-cycle event for the alert logic.

A read request works differently. The host writes the address and command, issues a repeated start and then sends the read address. For this case the CRC keeps running across the repeated start and stays visible on `o_crc`, so a separate read-response engine can append a correct checksum. The block itself reports nothing for a read frame.

The control is a state machine with five states. ST_IDLE is the state outside any frame. ST_ADDR waits for the address byte. ST_BODY collects the command, data and checksum bytes. ST_READ follows a read address or a valid repeated start and stays silent. ST_DROP holds a frame that is already known to be bad until its stop. The transitions are:
- start from any state goes to ST_ADDR.
- In ST_ADDR, a byte goes to ST_BODY when its LSB is 0 and to ST_READ when its LSB is 1.
- In ST_ADDR, a repeated start goes to ST_DROP.
- In ST_BODY, a repeated start after exactly one body byte goes to ST_READ. A repeated start at any other count goes to ST_DROP.
- In ST_BODY, a fifth body byte goes to ST_DROP.
- stop from any frame state goes to ST_IDLE, and the frame verdict is issued at the same edge.

Top module: `pmb_wr_rx`

## Requirements
- R1: After reset, `o_vld`, `o_pec_err` and `o_comm_err` are 0. `o_crc`, `o_cmd`, `o_data`, `o_len`, `o_pec_used` and `o_mfr` are all 0.
- R2: `o_crc` is a CRC-8 with generator 0x07. It is cleared to 0x00 by start and processes each byte MSB first, with no final XOR. It covers every byte from the address onward and holds its value between frames. Bytes that arrive outside a frame (in ST_IDLE) change nothing.
- R3: The expected data length of a command is fixed by its code. Code 0x03 has 0 bytes. Every other code from 0x00 to 0x1F has 1 byte. All remaining codes have 2 bytes.
- R4: A frame is address (LSB 0 = write), command, then exactly its expected number of data bytes, then stop. Such a frame pulses `o_vld` in the cycle after the stop edge, with `o_pec_used`=0. `o_data` is built with the first data byte as the low byte. `o_data` is 0x0000 for length 0 and 0x00nn for length 1. `o_len` gives the data length.
- R5: A frame with exactly one byte more than expected treats that last byte as a checksum and compares it with the CRC of all bytes before it. On a match, `o_vld` pulses with `o_pec_used`=1. On a mismatch, `o_pec_err` pulses instead, `o_vld` stays 0 and the held output fields keep their previous values.
- R6: A write frame with any other body length pulses `o_comm_err` at stop and produces no `o_vld`. This includes an address with no command and more than four body bytes.
- R7: A stop while `i_midbyte` is 1 inside a frame pulses `o_comm_err` and discards the frame.
- R8: A repeated start after exactly address and command enters the read phase. The CRC continues across it, and the final stop gives no event. A repeated start at any other point of a write frame makes its stop pulse `o_comm_err`.
- R9: A frame whose first byte has LSB 1 is a read frame. It gives no event at its stop.
- R10: `o_mfr` is 1 on an accepted command whose code is from 0xD0 to 0xEF inclusive, and 0 otherwise.
- R11: Strobes that coincide are ranked start, then repeated start, then stop, then byte. The lower-ranked strobes in that cycle are ignored. A start inside an open frame discards that frame without any event.
- R12: At most one of `o_vld`, `o_pec_err` and `o_comm_err` is high in a cycle. Each is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_start | input | 1 | Start condition strobe |
| i_rstart | input | 1 | Repeated start strobe |
| i_stop | input | 1 | Stop condition strobe |
| i_byte_vld | input | 1 | Received byte strobe |
| i_byte | input | 8 | Received byte |
| i_midbyte | input | 1 | Bit engine holds a partial byte |
| o_vld | output | 1 | Accepted write, one-cycle pulse |
| o_cmd | output | 8 | Command code of the last accepted write |
| o_data | output | 16 | Data word, high byte : low byte |
| o_len | output | 2 | Number of data bytes (0..2) |
| o_pec_used | output | 1 | The accepted write carried a checksum |
| o_mfr | output | 1 | The command is in the manufacturer range |
| o_pec_err | output | 1 | Checksum mismatch, one-cycle pulse |
| o_comm_err | output | 1 | Malformed or truncated frame, one-cycle pulse |
| o_crc | output | 8 | Running CRC of the current or last frame |

## Verification
The hardest cases to reach are the ones where the same byte count means different things depending on the command. For example, a frame of address, 0x03 and one more byte must be checked as a checksum frame. The same count with 0x01 is a plain one-byte write. The stimulus therefore sends frames of length L, L+1 and L+2 for each length class, with correct and with corrupted checksums. A second hard case is a strobe that arrives in the same cycle as another strobe. The bench drives a byte together with a stop and also restarts a frame in its middle. The read path is reached by a repeated start after address and command, and the expected CRC is carried across it.

// File: rtl/pmb_rx_pkg.sv
package pmb_rx_pkg;

    localparam int BYTE_W   = 8;
    localparam int WORD_W   = 2 * BYTE_W;
    localparam int MAX_DATA = 2;
    localparam int MAX_BODY = 1 + MAX_DATA + 1;
    localparam int NB_W     = $clog2(MAX_BODY + 2);
    localparam int LEN_W    = $clog2(MAX_DATA + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_BODY,
        ST_READ,
        ST_DROP
    } rx_state_t;

    typedef enum logic [2:0] {
        V_NONE,
        V_OK,
        V_OK_PEC,
        V_PEC_BAD,
        V_ERR
    } verdict_t;

    function automatic logic [BYTE_W-1:0] crc8_next(
        input logic [BYTE_W-1:0] cur,
        input logic [BYTE_W-1:0] din,
        input logic [BYTE_W-1:0] poly
    );
        logic [BYTE_W-1:0] r;
        r = cur ^ din;
        for (int i = 0; i < BYTE_W; i++) begin
            r = r[BYTE_W-1] ? ((r << 1) ^ poly) : (r << 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/pmb_rx_crc.sv
module pmb_rx_crc
    import pmb_rx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] POLY = 8'h07
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic [BYTE_W-1:0] crc,
    output logic [BYTE_W-1:0] crc_prev
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            crc      <= '0;
            crc_prev <= '0;
        end else if (clr) begin
            crc      <= '0;
            crc_prev <= '0;
        end else if (en) begin
            crc_prev <= crc;
            crc      <= crc8_next(crc, din, POLY);
        end
    end

    // R2: a start always seeds the register with zero
    p_crc_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr) |-> (crc == '0));

    // R2: without a counted byte the value stays put
    p_crc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !en) |=> $stable(crc));

endmodule

// File: rtl/pmb_rx_cmdlen.sv
module pmb_rx_cmdlen
    import pmb_rx_pkg::*;
#(
    parameter logic [BYTE_W-1:0] LEN0_LO = 8'h03,
    parameter logic [BYTE_W-1:0] LEN0_HI = 8'h03,
    parameter logic [BYTE_W-1:0] LEN1_LO = 8'h00,
    parameter logic [BYTE_W-1:0] LEN1_HI = 8'h1F,
    parameter logic [BYTE_W-1:0] MFR_LO  = 8'hD0,
    parameter logic [BYTE_W-1:0] MFR_HI  = 8'hEF
) (
    input  logic [BYTE_W-1:0] cmd,
    output logic [LEN_W-1:0]  len,
    output logic              mfr
);

    logic in_zero;
    logic in_one;

    always_comb begin
        in_zero = (cmd >= LEN0_LO) && (cmd <= LEN0_HI);
        in_one  = (cmd >= LEN1_LO) && (cmd <= LEN1_HI);
        if (in_zero) begin
            len = LEN_W'(0);
        end else if (in_one) begin
            len = LEN_W'(1);
        end else begin
            len = LEN_W'(MAX_DATA);
        end
        mfr = (cmd >= MFR_LO) && (cmd <= MFR_HI);
    end

endmodule

// File: rtl/pmb_rx_fsm.sv
module pmb_rx_fsm
    import pmb_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              i_start,
    input  logic              i_rstart,
    input  logic              i_stop,
    input  logic              i_byte_vld,
    input  logic [BYTE_W-1:0] i_byte,
    input  logic              i_midbyte,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_mfr,
    input  logic [BYTE_W-1:0] crc_prev,
    output logic              crc_clr,
    output logic              crc_en,
    output logic [BYTE_W-1:0] cmd_q,
    output logic              o_vld,
    output logic [BYTE_W-1:0] o_cmd,
    output logic [WORD_W-1:0] o_data,
    output logic [LEN_W-1:0]  o_len,
    output logic              o_pec_used,
    output logic              o_mfr,
    output logic              o_pec_err,
    output logic              o_comm_err
);

    rx_state_t         st, st_n;
    verdict_t          verdict;
    logic [NB_W-1:0]   nb;
    logic [BYTE_W-1:0] d_lo, d_hi, last_q;
    logic              ev_start, ev_rs, ev_stop, ev_byte;
    logic [NB_W-1:0]   want, want_pec;
    logic [WORD_W-1:0] word;

    // strobe ranking: start > repeated start > stop > byte
    always_comb begin
        ev_start = i_start;
        ev_rs    = i_rstart && !i_start;
        ev_stop  = i_stop && !i_start && !i_rstart;
        ev_byte  = i_byte_vld && !i_start && !i_rstart && !i_stop;
        crc_clr  = ev_start;
        crc_en   = ev_byte && (st != ST_IDLE);
    end

    // next state
    always_comb begin
        st_n = st;
        if (ev_start) begin
            st_n = ST_ADDR;
        end else if (ev_stop) begin
            st_n = ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: st_n = ST_IDLE;
                ST_ADDR: begin
                    if (ev_byte) begin
                        st_n = i_byte[0] ? ST_READ : ST_BODY;
                    end else if (ev_rs) begin
                        st_n = ST_DROP;
                    end
                end
                ST_BODY: begin
                    if (ev_byte && (nb == NB_W'(MAX_BODY))) begin
                        st_n = ST_DROP;
                    end else if (ev_rs) begin
                        st_n = (nb == NB_W'(1)) ? ST_READ : ST_DROP;
                    end
                end
                ST_READ: st_n = ST_READ;
                ST_DROP: st_n = ST_DROP;
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // verdict at stop
    always_comb begin
        want     = NB_W'(cmd_len) + NB_W'(1);
        want_pec = NB_W'(cmd_len) + NB_W'(2);
        verdict  = V_NONE;
        if (ev_stop) begin
            unique case (st)
                ST_IDLE: verdict = V_NONE;
                ST_ADDR,
                ST_READ: verdict = i_midbyte ? V_ERR : V_NONE;
                ST_DROP: verdict = V_ERR;
                ST_BODY: begin
                    if (i_midbyte || (nb == '0)) begin
                        verdict = V_ERR;
                    end else if (nb == want) begin
                        verdict = V_OK;
                    end else if (nb == want_pec) begin
                        verdict = (crc_prev == last_q) ? V_OK_PEC : V_PEC_BAD;
                    end else begin
                        verdict = V_ERR;
                    end
                end
                default: verdict = V_ERR;
            endcase
        end
    end

    always_comb begin
        if (cmd_len == LEN_W'(0)) begin
            word = '0;
        end else if (cmd_len == LEN_W'(1)) begin
            word = {{BYTE_W{1'b0}}, d_lo};
        end else begin
            word = {d_hi, d_lo};
        end
    end

    // state register and frame storage
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            nb     <= '0;
            cmd_q  <= '0;
            d_lo   <= '0;
            d_hi   <= '0;
            last_q <= '0;
        end else begin
            st <= st_n;
            if (ev_start) begin
                nb <= '0;
            end else if (ev_byte && (st == ST_BODY) && (nb != NB_W'(MAX_BODY))) begin
                nb     <= nb + NB_W'(1);
                last_q <= i_byte;
                unique case (nb)
                    NB_W'(0): cmd_q <= i_byte;
                    NB_W'(1): d_lo  <= i_byte;
                    NB_W'(2): d_hi  <= i_byte;
                    default:  ;
                endcase
            end
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            o_vld      <= 1'b0;
            o_pec_err  <= 1'b0;
            o_comm_err <= 1'b0;
            o_cmd      <= '0;
            o_data     <= '0;
            o_len      <= '0;
            o_pec_used <= 1'b0;
            o_mfr      <= 1'b0;
        end else begin
            o_vld      <= (verdict == V_OK) || (verdict == V_OK_PEC);
            o_pec_err  <= (verdict == V_PEC_BAD);
            o_comm_err <= (verdict == V_ERR);
            if ((verdict == V_OK) || (verdict == V_OK_PEC)) begin
                o_cmd      <= cmd_q;
                o_data     <= word;
                o_len      <= cmd_len;
                o_pec_used <= (verdict == V_OK_PEC);
                o_mfr      <= cmd_mfr;
            end
        end
    end

    // R12: events never overlap
    p_one_event_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_vld, o_pec_err, o_comm_err}));

    // R12: an accepted write is a single-cycle pulse
    p_vld_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |=> !o_vld);

    // R4: acceptance only follows a stop strobe
    p_vld_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> $past(i_stop));

    // R5: checksum error only follows a stop strobe
    p_pec_after_stop_r5: assert property (@(posedge clk) disable iff (!rst_n)
        o_pec_err |-> $past(i_stop));

    // R6: the body counter never passes its bound
    p_nb_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        nb <= NB_W'(MAX_BODY));

    // R8: a read phase ends silently when the byte was complete
    p_read_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_READ && ev_stop && !i_midbyte) |=> (!o_vld && !o_pec_err && !o_comm_err));

endmodule

// File: rtl/pmb_wr_rx.sv
module pmb_wr_rx
    import pmb_rx_pkg::*;
#(
    parameter logic [7:0] POLY    = 8'h07,
    parameter logic [7:0] LEN0_LO = 8'h03,
    parameter logic [7:0] LEN0_HI = 8'h03,
    parameter logic [7:0] LEN1_LO = 8'h00,
    parameter logic [7:0] LEN1_HI = 8'h1F,
    parameter logic [7:0] MFR_LO  = 8'hD0,
    parameter logic [7:0] MFR_HI  = 8'hEF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        i_start,
    input  logic        i_rstart,
    input  logic        i_stop,
    input  logic        i_byte_vld,
    input  logic [7:0]  i_byte,
    input  logic        i_midbyte,
    output logic        o_vld,
    output logic [7:0]  o_cmd,
    output logic [15:0] o_data,
    output logic [1:0]  o_len,
    output logic        o_pec_used,
    output logic        o_mfr,
    output logic        o_pec_err,
    output logic        o_comm_err,
    output logic [7:0]  o_crc
);

    logic              crc_clr, crc_en;
    logic [BYTE_W-1:0] crc_prev, cmd_q;
    logic [LEN_W-1:0]  cmd_len;
    logic              cmd_mfr;

    pmb_rx_crc #(.POLY(POLY)) u_crc (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (crc_clr),
        .en       (crc_en),
        .din      (i_byte),
        .crc      (o_crc),
        .crc_prev (crc_prev)
    );

    pmb_rx_cmdlen #(
        .LEN0_LO (LEN0_LO),
        .LEN0_HI (LEN0_HI),
        .LEN1_LO (LEN1_LO),
        .LEN1_HI (LEN1_HI),
        .MFR_LO  (MFR_LO),
        .MFR_HI  (MFR_HI)
    ) u_len (
        .cmd (cmd_q),
        .len (cmd_len),
        .mfr (cmd_mfr)
    );

    pmb_rx_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_start    (i_start),
        .i_rstart   (i_rstart),
        .i_stop     (i_stop),
        .i_byte_vld (i_byte_vld),
        .i_byte     (i_byte),
        .i_midbyte  (i_midbyte),
        .cmd_len    (cmd_len),
        .cmd_mfr    (cmd_mfr),
        .crc_prev   (crc_prev),
        .crc_clr    (crc_clr),
        .crc_en     (crc_en),
        .cmd_q      (cmd_q),
        .o_vld      (o_vld),
        .o_cmd      (o_cmd),
        .o_data     (o_data),
        .o_len      (o_len),
        .o_pec_used (o_pec_used),
        .o_mfr      (o_mfr),
        .o_pec_err  (o_pec_err),
        .o_comm_err (o_comm_err)
    );

    // R10: manufacturer tag agrees with the delivered command code
    p_mfr_tag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> (o_mfr == ((o_cmd >= MFR_LO) && (o_cmd <= MFR_HI))));

    // R4: the reported length is one of the legal ones
    p_len_legal_r4: assert property (@(posedge clk) disable iff (!rst_n)
        o_vld |-> (o_len <= 2'd2));

endmodule

// File: tb/sim_pmb_wr_rx.sv
module sim_pmb_wr_rx;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_start = 0, i_rstart = 0, i_stop = 0, i_byte_vld = 0, i_midbyte = 0;
    logic [7:0]  i_byte = 0;
    logic        o_vld, o_pec_used, o_mfr, o_pec_err, o_comm_err;
    logic [7:0]  o_cmd, o_crc;
    logic [15:0] o_data;
    logic [1:0]  o_len;

    always #5 clk = ~clk;

    pmb_wr_rx u0 (
        .clk(clk), .rst_n(rst_n), .i_start(i_start), .i_rstart(i_rstart),
        .i_stop(i_stop), .i_byte_vld(i_byte_vld), .i_byte(i_byte),
        .i_midbyte(i_midbyte), .o_vld(o_vld), .o_cmd(o_cmd), .o_data(o_data),
        .o_len(o_len), .o_pec_used(o_pec_used), .o_mfr(o_mfr),
        .o_pec_err(o_pec_err), .o_comm_err(o_comm_err), .o_crc(o_crc)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // reference model state
    logic [7:0]  q[$];
    logic [7:0]  fb[$];
    bit          in_frame = 0, rd = 0, drp = 0;
    bit          e_vld = 0, e_pec = 0, e_err = 0;
    logic [7:0]  h_cmd = 0;
    logic [15:0] h_data = 0;
    logic [1:0]  h_len = 0;
    bit          h_pu = 0, h_mfr = 0;

    // polynomial long division, bit serial over the whole message
    function automatic logic [7:0] crc_of(input logic [7:0] d[$], input int n);
        logic [7:0] c = 8'h00;
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                bit fbk = c[7] ^ d[k][b];
                c = {c[6:0], 1'b0};
                if (fbk) c = c ^ 8'h07;
            end
        end
        return c;
    endfunction

    function automatic int exp_len(input logic [7:0] c);
        if (c == 8'h03) return 0;
        if (c <= 8'h1F) return 1;
        return 2;
    endfunction

    task automatic chk(input string tag, input string nm, input logic [15:0] act, input logic [15:0] exp, inout bit bad);
        if (act !== exp) begin
            $display("FAIL %s %s actual %0h expected %0h", tag, nm, act, exp);
            bad = 1;
        end
    endtask

    task automatic step(input string tag);
        bit bad = 0;
        @(negedge clk);
        n_chk++;
        chk(tag, "o_vld", 16'(o_vld), 16'(e_vld), bad);
        chk(tag, "o_pec_err", 16'(o_pec_err), 16'(e_pec), bad);
        chk(tag, "o_comm_err", 16'(o_comm_err), 16'(e_err), bad);
        chk(tag, "o_crc", 16'(o_crc), 16'(crc_of(q, q.size())), bad);
        chk(tag, "o_cmd", 16'(o_cmd), 16'(h_cmd), bad);
        chk(tag, "o_data", o_data, h_data, bad);
        chk(tag, "o_len", 16'(o_len), 16'(h_len), bad);
        chk(tag, "o_pec_used", 16'(o_pec_used), 16'(h_pu), bad);
        chk(tag, "o_mfr", 16'(o_mfr), 16'(h_mfr), bad);
        if (bad) n_fail++;
        e_vld = 0; e_pec = 0; e_err = 0;
        i_start = 0; i_rstart = 0; i_stop = 0; i_byte_vld = 0; i_midbyte = 0;
    endtask

    task automatic do_start(input string tag);
        i_start = 1;
        q.delete(); in_frame = 1; rd = 0; drp = 0;
        step(tag);
    endtask

    task automatic do_byte(input logic [7:0] b, input string tag);
        i_byte_vld = 1; i_byte = b;
        if (in_frame) begin
            if (q.size() == 0 && !drp && b[0]) rd = 1;
            q.push_back(b);
        end
        step(tag);
    endtask

    task automatic do_rstart(input string tag);
        i_rstart = 1;
        if (in_frame && !drp && !rd) begin
            if (q.size() == 2) rd = 1; else drp = 1;
        end
        step(tag);
    endtask

    task automatic do_stop(input bit mid, input string tag);
        i_stop = 1; i_midbyte = mid;
        if (in_frame) begin
            if (drp) e_err = 1;
            else if (rd || q.size() == 0) e_err = mid;
            else if (mid) e_err = 1;
            else begin
                int n = q.size() - 1;
                int l;
                if (n == 0 || n > 4) e_err = 1;
                else begin
                    l = exp_len(q[1]);
                    if (n == l + 1 || (n == l + 2 && crc_of(q, q.size() - 1) == q[q.size()-1])) begin
                        e_vld = 1;
                        h_cmd = q[1]; h_len = 2'(l); h_pu = (n == l + 2);
                        h_mfr = (q[1] >= 8'hD0 && q[1] <= 8'hEF);
                        h_data = (l == 0) ? 16'h0 : (l == 1) ? {8'h00, q[2]} : {q[3], q[2]};
                    end else if (n == l + 2) e_pec = 1;
                    else e_err = 1;
                end
            end
        end
        in_frame = 0;
        step(tag);
    endtask

    // whole frame from fb, optional appended checksum (good or corrupted)
    task automatic frame(input int pec_mode, input string tag);
        if (pec_mode != 0) fb.push_back(crc_of(fb, fb.size()) ^ ((pec_mode == 2) ? 8'h01 : 8'h00));
        do_start(tag);
        foreach (fb[k]) do_byte(fb[k], tag);
        do_stop(0, tag);
        fb.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        step("R1 reset state");
        // bytes outside a frame
        do_byte(8'h5A, "R2 idle byte ignored");
        do_stop(1, "R2 idle stop ignored");
        // lengths without checksum
        fb = '{8'hB0, 8'h03};            frame(0, "R3 R4 send-byte");
        fb = '{8'hB0, 8'h01, 8'h80};     frame(0, "R3 R4 one byte");
        fb = '{8'hB0, 8'h21, 8'h34, 8'h12}; frame(0, "R3 R4 word low first");
        // checksum frames
        fb = '{8'hB0, 8'h03};            frame(1, "R5 pec len0");
        fb = '{8'hB0, 8'h01, 8'h40};     frame(1, "R5 pec len1");
        fb = '{8'hB0, 8'h21, 8'hCD, 8'hAB}; frame(1, "R5 pec word");
        fb = '{8'hB0, 8'h21, 8'h11, 8'h22}; frame(2, "R5 pec mismatch");
        fb = '{8'hB0, 8'h03};            frame(2, "R5 pec mismatch len0");
        // wrong lengths
        fb = '{8'hB0};                   frame(0, "R6 address only");
        fb = '{8'hB0, 8'h21, 8'h34};     frame(0, "R6 short word");
        fb = '{8'hB0, 8'h21, 1, 2, 3, 4}; frame(0, "R6 overflow");
        fb = '{8'hB0, 8'h01, 1, 2, 3};   frame(0, "R6 long byte");
        // truncated
        do_start("R7 start"); do_byte(8'hB0, "R7"); do_byte(8'h03, "R7");
        do_stop(1, "R7 midbyte stop");
        do_start("R7 start2"); do_stop(1, "R7 midbyte in address");
        // read request
        do_start("R8 start"); do_byte(8'hB0, "R8"); do_byte(8'h8B, "R8");
        do_rstart("R8 rstart"); do_byte(8'hB1, "R8 crc continues");
        do_byte(8'h55, "R8 crc continues"); do_stop(0, "R8 silent stop");
        do_start("R8 bad"); do_byte(8'hB0, "R8"); do_byte(8'h21, "R8"); do_byte(8'h34, "R8");
        do_rstart("R8 rstart late"); do_stop(0, "R8 late rstart error");
        do_start("R8 bad2"); do_rstart("R8 rstart early"); do_byte(8'hB1, "R8"); do_stop(0, "R8 early rstart error");
        // read address first
        fb = '{8'hB1, 8'h03};            frame(0, "R9 read frame silent");
        // manufacturer range boundaries
        fb = '{8'hB0, 8'hD0, 8'h01, 8'h02}; frame(0, "R10 low edge");
        fb = '{8'hB0, 8'hEF, 8'h03, 8'h04}; frame(1, "R10 high edge");
        fb = '{8'hB0, 8'hF0, 8'h05, 8'h06}; frame(0, "R10 above");
        fb = '{8'hB0, 8'hCF, 8'h07, 8'h08}; frame(0, "R10 below");
        // strobe ranking and restart
        do_start("R11 start"); do_byte(8'hB0, "R11"); do_byte(8'h21, "R11");
        do_start("R11 restart"); do_byte(8'hB0, "R11"); do_byte(8'h03, "R11");
        do_stop(0, "R11 restarted frame");
        do_start("R11 coincide"); do_byte(8'hB0, "R11"); do_byte(8'h03, "R11");
        i_byte_vld = 1; i_byte = 8'h77;
        do_stop(0, "R11 stop beats byte");
        do_start("R11 start beats stop"); do_byte(8'hB0, "R11");
        i_stop = 1; do_start("R11 start beats stop");
        do_byte(8'hB0, "R11"); do_byte(8'h03, "R11"); do_stop(0, "R11 frame survives");
        step("R12 pulse drops");
        step("R12 quiet");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule